// File: doc/BRIEF.md
# Tag-Matching Reservation Station Array

This block holds instructions that have been dispatched but cannot start yet because an operand is still missing. There is one station for each functional-unit class: integer ALU, load, store, and two floating-point units. Each station records the opcode, the reorder-buffer tag its result will carry, and a tag and a value for each of its two source operands. A source tag of zero means the value is present. A nonzero tag names the reorder-buffer entry that will produce the value.

When an instruction is dispatched, each source is resolved in one of three ways. It may come from the register file, or from the reorder buffer if that entry already holds its result. Otherwise the station keeps the tag and watches the result broadcast bus for it. When the tag is seen on the bus, the station takes the broadcast value. A station with both operands present raises a request to its functional unit. The unit accepts by pulsing its go bit, and the station is then free. It can take a new instruction in that same cycle. Dispatch stalls when the station for the requested class is occupied. A flush empties every station.

Top module: `rs_array`

## Requirements
- R1: After reset, no station requests issue, and `disp_stall` is low while `disp_valid` is low.
- R2: `disp_cls` picks the station: 0 ALU, 1 load, 2 store, 3 FP unit 1, 4 FP unit 2. An accepted dispatch shows its opcode and destination tag on that station's slice of `iss_op` and `iss_dst` from the next cycle.
- R3: A source whose tag is zero is filled from its register-file value input and counts as ready.
- R4: A source with a nonzero tag and its in-buffer flag set is filled from its reorder-buffer value input and counts as ready. This takes priority over a broadcast in the same cycle.
- R5: A source with a nonzero tag and no in-buffer flag keeps its tag. It becomes ready with the broadcast value in the cycle after `cdb_valid` carries an equal tag. Broadcasts with any other tag, including tag zero, change nothing.
- R6: A broadcast in the same cycle as the dispatch, with a tag equal to a pending source tag, fills that source at dispatch.
- R7: `iss_req[i]` is high exactly when station i is occupied and both of its sources are ready. It stays high until `iss_go[i]` is sampled high.
- R8: `disp_stall` is high when `disp_valid` is high and either `disp_cls` is 5 or more, or the selected station is occupied and not issuing in that cycle. A stalled dispatch changes no station.
- R9: A station with `iss_req` and `iss_go` both high is free in the next cycle. A dispatch to that station in the same cycle is accepted and takes its place.
- R10: `flush` empties every station in the next cycle, and a dispatch in the flush cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties all stations |
| disp_valid | input | 1 | Dispatch request |
| disp_cls | input | CLS_W | Unit class of the dispatched instruction |
| disp_op | input | OP_W | Opcode |
| disp_dst | input | TAG_W | Destination reorder-buffer tag |
| disp_t1 | input | TAG_W | Source 1 tag (0 = register file) |
| disp_t1_inrob | input | 1 | Source 1 result already in the reorder buffer |
| disp_rf1 | input | DATA_W | Source 1 register-file value |
| disp_rob1 | input | DATA_W | Source 1 reorder-buffer value |
| disp_t2 | input | TAG_W | Source 2 tag (0 = register file) |
| disp_t2_inrob | input | 1 | Source 2 result already in the reorder buffer |
| disp_rf2 | input | DATA_W | Source 2 register-file value |
| disp_rob2 | input | DATA_W | Source 2 reorder-buffer value |
| disp_stall | output | 1 | Dispatch cannot be accepted this cycle |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | TAG_W | Broadcast tag |
| cdb_val | input | DATA_W | Broadcast value |
| iss_go | input | NUM_ST | Per-station start of execution |
| iss_req | output | NUM_ST | Per-station ready-to-issue |
| iss_op | output | NUM_ST*OP_W | Per-station opcode |
| iss_dst | output | NUM_ST*TAG_W | Per-station destination tag |
| iss_v1 | output | NUM_ST*DATA_W | Per-station source 1 value |
| iss_v2 | output | NUM_ST*DATA_W | Per-station source 2 value |

## Verification
The assertions assume that tag zero is never used for a live reorder-buffer entry. They also assume that a station waits on at most one producer for each source, so one matching broadcast fully wakes that source. The stimulus follows both rules: every pending tag in it is nonzero, and each tag is broadcast at most once while it is outstanding. The unit class is driven out of range only to check the stall. A go bit is raised only in cycles where the bench expects the request to be high.

// File: rtl/rs_array.sv
module rs_array #(
  parameter int NUM_ST = 5,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  parameter int OP_W   = 4,
  localparam int CLS_W = (NUM_ST > 1) ? $clog2(NUM_ST) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     disp_valid,
  input  logic [CLS_W-1:0]         disp_cls,
  input  logic [OP_W-1:0]          disp_op,
  input  logic [TAG_W-1:0]         disp_dst,
  input  logic [TAG_W-1:0]         disp_t1,
  input  logic                     disp_t1_inrob,
  input  logic [DATA_W-1:0]        disp_rf1,
  input  logic [DATA_W-1:0]        disp_rob1,
  input  logic [TAG_W-1:0]         disp_t2,
  input  logic                     disp_t2_inrob,
  input  logic [DATA_W-1:0]        disp_rf2,
  input  logic [DATA_W-1:0]        disp_rob2,
  output logic                     disp_stall,
  input  logic                     cdb_valid,
  input  logic [TAG_W-1:0]         cdb_tag,
  input  logic [DATA_W-1:0]        cdb_val,
  input  logic [NUM_ST-1:0]        iss_go,
  output logic [NUM_ST-1:0]        iss_req,
  output logic [NUM_ST*OP_W-1:0]   iss_op,
  output logic [NUM_ST*TAG_W-1:0]  iss_dst,
  output logic [NUM_ST*DATA_W-1:0] iss_v1,
  output logic [NUM_ST*DATA_W-1:0] iss_v2
);

  logic [TAG_W-1:0]  in_t1, in_t2;
  logic [DATA_W-1:0] in_v1, in_v2;
  logic [NUM_ST-1:0] fire, slot_ok, alloc;

  assign in_t1 = (disp_t1 == '0 || disp_t1_inrob || (cdb_valid && cdb_tag == disp_t1)) ? '0 : disp_t1;
  assign in_v1 = (disp_t1 == '0) ? disp_rf1 : (disp_t1_inrob ? disp_rob1 : cdb_val);
  assign in_t2 = (disp_t2 == '0 || disp_t2_inrob || (cdb_valid && cdb_tag == disp_t2)) ? '0 : disp_t2;
  assign in_v2 = (disp_t2 == '0) ? disp_rf2 : (disp_t2_inrob ? disp_rob2 : cdb_val);

  assign fire       = iss_req & iss_go;
  assign disp_stall = disp_valid && (slot_ok == '0);
  assign alloc      = slot_ok & {NUM_ST{disp_valid && !flush}};

  for (genvar i = 0; i < NUM_ST; i++) begin : g_st
    logic              busy_q;
    logic [OP_W-1:0]   op_q;
    logic [TAG_W-1:0]  dst_q, t1_q, t2_q;
    logic [DATA_W-1:0] v1_q, v2_q;
    logic              hit1, hit2;

    assign slot_ok[i] = (disp_cls == CLS_W'(i)) && (!busy_q || fire[i]);
    assign hit1 = cdb_valid && busy_q && t1_q != '0 && cdb_tag == t1_q;
    assign hit2 = cdb_valid && busy_q && t2_q != '0 && cdb_tag == t2_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_q <= 1'b0;
        op_q   <= '0;
        dst_q  <= '0;
        t1_q   <= '0;
        t2_q   <= '0;
        v1_q   <= '0;
        v2_q   <= '0;
      end else if (flush) begin
        busy_q <= 1'b0;
      end else if (alloc[i]) begin
        busy_q <= 1'b1;
        op_q   <= disp_op;
        dst_q  <= disp_dst;
        t1_q   <= in_t1;
        t2_q   <= in_t2;
        v1_q   <= in_v1;
        v2_q   <= in_v2;
      end else begin
        if (fire[i]) busy_q <= 1'b0;
        if (hit1) begin
          t1_q <= '0;
          v1_q <= cdb_val;
        end
        if (hit2) begin
          t2_q <= '0;
          v2_q <= cdb_val;
        end
      end
    end

    assign iss_req[i] = busy_q && t1_q == '0 && t2_q == '0;
    assign iss_op[i*OP_W +: OP_W]       = op_q;
    assign iss_dst[i*TAG_W +: TAG_W]    = dst_q;
    assign iss_v1[i*DATA_W +: DATA_W]   = v1_q;
    assign iss_v2[i*DATA_W +: DATA_W]   = v2_q;

    AST_WAKE_SRC1: assert property (@(posedge clk) disable iff (!rst_n)
      (hit1 && !flush && !alloc[i]) |=> (t1_q == '0 && v1_q == $past(cdb_val))); // R5
    AST_WAKE_SRC2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit2 && !flush && !alloc[i]) |=> (t2_q == '0 && v2_q == $past(cdb_val))); // R5
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_req[i] && !iss_go[i] && !flush) |=> iss_req[i]); // R7
    AST_ISSUE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      (fire[i] && !alloc[i]) |=> !busy_q); // R9
    AST_STALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_stall && disp_cls == CLS_W'(i)) |=> ($stable(op_q) && $stable(dst_q))); // R8
  end

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (iss_req == '0)); // R10
  AST_ONE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc)); // R2

endmodule

// File: tb/tb_rs_array.sv
module tb_rs_array;
  localparam int N = 5, TW = 4, DW = 16, OW = 4, CW = 3;

  logic clk = 0, rst_n = 0, flush = 0;
  logic disp_valid = 0;
  logic [CW-1:0] disp_cls = '0;
  logic [OW-1:0] disp_op = '0;
  logic [TW-1:0] disp_dst = '0, disp_t1 = '0, disp_t2 = '0;
  logic disp_t1_inrob = 0, disp_t2_inrob = 0;
  logic [DW-1:0] disp_rf1 = '0, disp_rob1 = '0, disp_rf2 = '0, disp_rob2 = '0;
  logic disp_stall;
  logic cdb_valid = 0;
  logic [TW-1:0] cdb_tag = '0;
  logic [DW-1:0] cdb_val = '0;
  logic [N-1:0] iss_go = '0, iss_req;
  logic [N*OW-1:0] iss_op;
  logic [N*TW-1:0] iss_dst;
  logic [N*DW-1:0] iss_v1, iss_v2;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  rs_array dut (.*);

  typedef struct packed {
    logic [2:0]  cls;
    logic [3:0]  op, dst, t1;
    logic        r1;
    logic [15:0] rf1, rob1;
    logic [3:0]  t2;
    logic        r2;
    logic [15:0] rf2, rob2;
    logic        cv;
    logic [3:0]  ct;
    logic [15:0] cval;
    logic        er;
    logic [15:0] ev1, ev2;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{3'd0, 4'd1, 4'd1, 4'd0, 1'b0, 16'h1111, 16'h0, 4'd0, 1'b0, 16'h2222, 16'h0, 1'b0, 4'd0, 16'h0,    1'b1, 16'h1111, 16'h2222},
    '{3'd1, 4'd2, 4'd2, 4'd3, 1'b1, 16'h0,    16'h3333, 4'd0, 1'b0, 16'h4444, 16'h0, 1'b0, 4'd0, 16'h0, 1'b1, 16'h3333, 16'h4444},
    '{3'd2, 4'd3, 4'd3, 4'd5, 1'b0, 16'h0,    16'h0, 4'd0, 1'b0, 16'h5555, 16'h0, 1'b0, 4'd0, 16'h0,    1'b0, 16'h0,    16'h5555},
    '{3'd3, 4'd4, 4'd4, 4'd6, 1'b0, 16'h0,    16'h0, 4'd7, 1'b1, 16'h0, 16'h7777, 1'b1, 4'd6, 16'h6666, 1'b1, 16'h6666, 16'h7777},
    '{3'd4, 4'd5, 4'd5, 4'd0, 1'b0, 16'h0a0a, 16'h0, 4'd9, 1'b0, 16'h0, 16'h0, 1'b1, 4'd8, 16'hbeef,    1'b0, 16'h0a0a, 16'h0},
    '{3'd4, 4'd6, 4'd7, 4'd2, 1'b1, 16'h0,    16'h1212, 4'd4, 1'b1, 16'h0, 16'h3434, 1'b1, 4'd2, 16'hdead, 1'b1, 16'h1212, 16'h3434}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic idle();
    disp_valid = 0; cdb_valid = 0; iss_go = '0; flush = 0;
    disp_t1 = '0; disp_t2 = '0; disp_t1_inrob = 0; disp_t2_inrob = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic disp(input logic [2:0] c, input logic [3:0] op, input logic [3:0] d,
                      input logic [3:0] t1, input logic [15:0] rf1, input logic [3:0] t2, input logic [15:0] rf2);
    disp_valid = 1; disp_cls = c; disp_op = op; disp_dst = d;
    disp_t1 = t1; disp_rf1 = rf1; disp_t1_inrob = 0;
    disp_t2 = t2; disp_rf2 = rf2; disp_t2_inrob = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 req", 32'(iss_req), 0);
    chk("R1 stall", 32'(disp_stall), 0);

    for (int k = 0; k < 6; k++) begin
      vec_t v = VEC[k];
      disp_valid = 1; disp_cls = v.cls; disp_op = v.op; disp_dst = v.dst;
      disp_t1 = v.t1; disp_t1_inrob = v.r1; disp_rf1 = v.rf1; disp_rob1 = v.rob1;
      disp_t2 = v.t2; disp_t2_inrob = v.r2; disp_rf2 = v.rf2; disp_rob2 = v.rob2;
      cdb_valid = v.cv; cdb_tag = v.ct; cdb_val = v.cval;
      #1 chk("R8 no stall on free", 32'(disp_stall), 0);
      step();
      idle();
      chk("R7 req R3 R4 R5 R6", 32'(iss_req[v.cls]), 32'(v.er));
      chk("R2 op", 32'(iss_op[v.cls*OW +: OW]), 32'(v.op));
      chk("R2 dst", 32'(iss_dst[v.cls*TW +: TW]), 32'(v.dst));
      if (v.er) begin
        chk("R3 R4 R6 v1", 32'(iss_v1[v.cls*DW +: DW]), 32'(v.ev1));
        chk("R3 R4 v2", 32'(iss_v2[v.cls*DW +: DW]), 32'(v.ev2));
      end
      flush = 1;
      step();
      idle();
      chk("R10 flush empties", 32'(iss_req), 0);
    end

    // R5: wakeup by broadcast, non-matching and zero tags ignored
    disp(3'd2, 4'd3, 4'd3, 4'd5, 16'h0, 4'd0, 16'h5555);
    step(); idle();
    chk("R5 pending", 32'(iss_req[2]), 0);
    cdb_valid = 1; cdb_tag = 4'd6; cdb_val = 16'h9999;
    step(); idle();
    chk("R5 other tag ignored", 32'(iss_req[2]), 0);
    cdb_valid = 1; cdb_tag = 4'd0; cdb_val = 16'h8888;
    step(); idle();
    chk("R5 tag zero ignored", 32'(iss_req[2]), 0);
    chk("R5 tag zero keeps v2", 32'(iss_v2[2*DW +: DW]), 32'h5555);
    cdb_valid = 1; cdb_tag = 4'd5; cdb_val = 16'habcd;
    step(); idle();
    chk("R5 woken", 32'(iss_req[2]), 1);
    chk("R5 captured v1", 32'(iss_v1[2*DW +: DW]), 32'habcd);

    // R7 hold, R9 free
    step();
    chk("R7 held", 32'(iss_req[2]), 1);
    iss_go[2] = 1;
    step(); idle();
    chk("R9 freed", 32'(iss_req[2]), 0);

    // R8 stall when busy
    disp(3'd0, 4'd1, 4'd1, 4'd0, 16'h0101, 4'd0, 16'h0202);
    step(); idle();
    disp(3'd0, 4'd7, 4'd2, 4'd0, 16'h0, 4'd0, 16'h0);
    #1 chk("R8 stall busy", 32'(disp_stall), 1);
    step(); idle();
    chk("R8 stalled no change", 32'(iss_op[0 +: OW]), 1);
    // R9 free and refill in one cycle
    disp(3'd0, 4'd9, 4'd3, 4'd0, 16'h0c0c, 4'd0, 16'h0d0d);
    iss_go[0] = 1;
    #1 chk("R9 no stall on issue", 32'(disp_stall), 0);
    step(); idle();
    chk("R9 refilled req", 32'(iss_req[0]), 1);
    chk("R9 refilled op", 32'(iss_op[0 +: OW]), 9);
    // R8 out-of-range class
    disp(3'd5, 4'd1, 4'd1, 4'd0, 16'h0, 4'd0, 16'h0);
    #1 chk("R8 bad class stall", 32'(disp_stall), 1);
    step(); idle();
    chk("R8 bad class no effect", 32'(iss_req), 1);

    // R10 dispatch during flush is dropped
    disp(3'd1, 4'd2, 4'd2, 4'd0, 16'h0, 4'd0, 16'h0);
    flush = 1;
    step(); idle();
    chk("R10 flush drops dispatch", 32'(iss_req), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule